// File: doc/BRIEF.md
# Window-Guarded Byte Memory with Port Bridge

This block sits between an 8-bit processor bus and a byte-wide store. The processor reads and writes bytes by 16-bit address. Before a write reaches the store, a guard unit compares its address against a few programmable address windows. A write that falls inside an active window is dropped with no error signal. A read returns the stored byte one cycle after it is requested.

A second write path serves a debug or host agent. It keeps its own 16-bit pointer, which can be loaded and then steps forward after every debug write, wrapping from 0xFFFF to 0x0000. The window guard applies to this path as well. When both paths write in the same cycle, the processor wins and the debug write is lost.

Port (I/O) accesses are forwarded to an optional peripheral. The peripheral receives the full 16-bit port number and the low data byte. When no peripheral is present, port reads return the floating-bus byte 0xFF and port writes are discarded.

Top module: `guarded_mem_bridge`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00 and all four window slots are inactive, so a write to any address lands.
- R2: A read with `cpu_rd` high presents the byte at `cpu_addr` on `cpu_rdata` after the next rising edge. The read sees the contents before any write in the same cycle. `cpu_rdata` holds its value in cycles without a read.
- R3: A processor write to an unguarded address stores the low 8 bits of `cpu_wdata`. A read issued in the next cycle returns that byte. The store holds 2^STORE_AW bytes (1024 by default) and is indexed by the low STORE_AW address bits.
- R4: A processor write whose address A satisfies lo <= A <= hi for any active slot (both bounds inclusive) leaves the store unchanged. Addresses lo-1 and hi+1 are written normally.
- R5: A slot loaded with its valid bit at 0 never guards an address. A slot whose lo is greater than its hi matches no address.
- R6: Debug writes are checked against the same windows. A guarded debug write leaves the store unchanged.
- R7: `dbg_load` sets the debug pointer to `dbg_addr`, and a write requested in that same cycle is ignored. Each other cycle with `dbg_wr` high and `cpu_wr` low writes the low byte of `dbg_wdata` at the pointer, unless the address is guarded, and then advances the pointer by one modulo 65536 (0xFFFF is followed by 0x0000).
- R8: In a cycle where `cpu_wr` and `dbg_wr` are both high, only the processor write is performed. The debug write is lost and the pointer does not advance.
- R9: `io_rdata` is combinational. It equals `per_rdata` when `per_present` is 1 and 0xFF when `per_present` is 0.
- R10: `per_rd` and `per_wr` follow `io_rd` and `io_wr` only while `per_present` is 1. `per_port` carries all 16 bits of `io_port`, and `per_wdata` carries the low 8 bits of `io_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load a window slot |
| cfg_slot | input | 2 | Slot index to load |
| cfg_valid | input | 1 | Active bit for the loaded slot |
| cfg_lo | input | 16 | Lowest guarded address (inclusive) |
| cfg_hi | input | 16 | Highest guarded address (inclusive) |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_addr | input | 16 | Processor memory address |
| cpu_wdata | input | 16 | Processor write data (low byte kept) |
| cpu_rdata | output | 8 | Read data, one cycle after the request |
| dbg_load | input | 1 | Load the debug pointer |
| dbg_addr | input | 16 | Debug pointer load value |
| dbg_wr | input | 1 | Debug write at the pointer |
| dbg_wdata | input | 16 | Debug write data (low byte kept) |
| io_rd | input | 1 | Processor port read |
| io_wr | input | 1 | Processor port write |
| io_port | input | 16 | Port number |
| io_wdata | input | 16 | Port write data |
| io_rdata | output | 8 | Port read data |
| per_present | input | 1 | A peripheral answers port cycles |
| per_rdata | input | 8 | Peripheral read data |
| per_rd | output | 1 | Port read forwarded to the peripheral |
| per_wr | output | 1 | Port write forwarded to the peripheral |
| per_port | output | 16 | Port number to the peripheral |
| per_wdata | output | 8 | Port write byte to the peripheral |

## Verification
The window guard is tried with writes at each bound of a window, one address inside each bound and one address outside each bound. This shows whether the comparison is inclusive and whether it is off by one. An inactive slot and a slot with inverted bounds separate valid-bit gating from plain range comparison. The debug path is run from a loaded pointer through 0xFFFF and into 0x0000, which shows whether the pointer wraps. It is also run in the same cycle as a processor write, which shows both that the processor wins and that the pointer stays put. Port reads and writes with and without a peripheral separate the floating-bus default from forwarding.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_t;

  // Inclusive window comparison; an inactive slot never matches.
  function automatic logic win_hit(win_t w, logic [ADDR_W-1:0] a);
    return w.valid && (a >= w.lo) && (a <= w.hi);
  endfunction

  // Next address, modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] addr_next(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // Low byte of a value of up to 32 bits.
  function automatic logic [BYTE_W-1:0] low_byte(logic [31:0] v);
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/pb_window_unit.sv
module pb_window_unit
  import pb_pkg::*;
#(
  parameter int N_WIN  = 4,
  parameter int SLOT_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] cfg_lo,
  input  logic [ADDR_W-1:0] cfg_hi,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              hit_a,
  output logic              hit_b
);
  logic [N_WIN-1:0] hv_a;
  logic [N_WIN-1:0] hv_b;

  for (genvar s = 0; s < N_WIN; s++) begin : g_slot
    win_t w_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        w_q <= '0;
      end else if (cfg_we && (cfg_slot == SLOT_W'(s))) begin
        w_q <= '{valid: cfg_valid, lo: cfg_lo, hi: cfg_hi};
      end
    end
    assign hv_a[s] = win_hit(w_q, addr_a);
    assign hv_b[s] = win_hit(w_q, addr_b);
  end

  assign hit_a = |hv_a;
  assign hit_b = |hv_b;
endmodule

// File: rtl/pb_byte_store.sv
module pb_byte_store
  import pb_pkg::*;
#(
  parameter int STORE_AW = 10,
  localparam int DEPTH   = 1 << STORE_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [STORE_AW-1:0] waddr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                re,
  input  logic [STORE_AW-1:0] raddr,
  output logic [BYTE_W-1:0]   rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pb_dbg_ptr.sv
module pb_dbg_ptr
  import pb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (step) ptr <= addr_next(ptr);
  end
endmodule

// File: rtl/pb_port_bridge.sv
module pb_port_bridge
  import pb_pkg::*;
#(
  parameter int WIDE_W = 16,
  parameter logic [BYTE_W-1:0] FLOAT_BYTE = 8'hFF
) (
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_port,
  input  logic [WIDE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic              per_present,
  input  logic [BYTE_W-1:0] per_rdata,
  output logic              per_rd,
  output logic              per_wr,
  output logic [ADDR_W-1:0] per_port,
  output logic [BYTE_W-1:0] per_wdata
);
  always_comb begin
    per_rd    = io_rd & per_present;
    per_wr    = io_wr & per_present;
    per_port  = io_port;
    per_wdata = low_byte(32'(io_wdata));
    io_rdata  = per_present ? per_rdata : FLOAT_BYTE;
  end
endmodule

// File: rtl/guarded_mem_bridge.sv
module guarded_mem_bridge
  import pb_pkg::*;
#(
  parameter int N_WIN    = 4,
  parameter int STORE_AW = 10,
  parameter int WIDE_W   = 16,
  localparam int SLOT_W  = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_valid,
  input  logic [15:0]       cfg_lo,
  input  logic [15:0]       cfg_hi,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [WIDE_W-1:0] cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              dbg_load,
  input  logic [15:0]       dbg_addr,
  input  logic              dbg_wr,
  input  logic [WIDE_W-1:0] dbg_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [15:0]       io_port,
  input  logic [WIDE_W-1:0] io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              per_present,
  input  logic [7:0]        per_rdata,
  output logic              per_rd,
  output logic              per_wr,
  output logic [15:0]       per_port,
  output logic [7:0]        per_wdata
);
  // Named internal events
  logic              cpu_hit;
  logic              dbg_hit;
  logic [ADDR_W-1:0] dbg_ptr;
  logic              dbg_active;
  logic              dbg_step;
  logic              cpu_wr_ok;
  logic              dbg_wr_ok;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr16;
  logic [BYTE_W-1:0] mem_wdata;

  pb_window_unit #(.N_WIN(N_WIN)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_valid(cfg_valid),
    .cfg_lo   (cfg_lo),
    .cfg_hi   (cfg_hi),
    .addr_a   (cpu_addr),
    .addr_b   (dbg_ptr),
    .hit_a    (cpu_hit),
    .hit_b    (dbg_hit)
  );

  // Debug path: load wins over write; processor write overrules it.
  assign dbg_active = dbg_wr & ~dbg_load;
  assign dbg_step   = dbg_active & ~cpu_wr;
  assign dbg_wr_ok  = dbg_step & ~dbg_hit;
  assign cpu_wr_ok  = cpu_wr & ~cpu_hit;

  pb_dbg_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dbg_load),
    .load_addr(dbg_addr),
    .step     (dbg_step),
    .ptr      (dbg_ptr)
  );

  always_comb begin
    mem_we      = cpu_wr_ok | dbg_wr_ok;
    mem_waddr16 = cpu_wr ? cpu_addr : dbg_ptr;
    mem_wdata   = cpu_wr ? low_byte(32'(cpu_wdata)) : low_byte(32'(dbg_wdata));
  end

  pb_byte_store #(.STORE_AW(STORE_AW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(mem_waddr16[STORE_AW-1:0]),
    .wdata(mem_wdata),
    .re   (cpu_rd),
    .raddr(cpu_addr[STORE_AW-1:0]),
    .rdata(cpu_rdata)
  );

  pb_port_bridge #(.WIDE_W(WIDE_W)) u_port (
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_port    (io_port),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .per_present(per_present),
    .per_rdata  (per_rdata),
    .per_rd     (per_rd),
    .per_wr     (per_wr),
    .per_port   (per_port),
    .per_wdata  (per_wdata)
  );
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int WIDE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [15:0]       cpu_addr,
  input logic [WIDE_W-1:0] cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic              dbg_load,
  input logic              dbg_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              per_present,
  input logic              per_rd,
  input logic              per_wr,
  input logic              cpu_hit,
  input logic              dbg_hit,
  input logic [15:0]       dbg_ptr,
  input logic              mem_we,
  input logic [15:0]       mem_waddr16,
  input logic [7:0]        mem_wdata
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata)); // R2

  AST_CPU_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !cpu_hit |-> mem_we && mem_waddr16 == cpu_addr && mem_wdata == cpu_wdata[7:0]); // R3

  AST_CPU_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_hit |-> !mem_we); // R4

  AST_DBG_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr && !dbg_load && !cpu_wr && dbg_hit |-> !mem_we); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr && !dbg_load && !cpu_wr |=> dbg_ptr == 16'($past(dbg_ptr) + 16'd1)); // R7

  AST_DBG_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr && !dbg_load && cpu_wr |=> dbg_ptr == $past(dbg_ptr)); // R8

  AST_FLOAT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !per_present |-> io_rdata == 8'hFF); // R9

  AST_NO_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    !per_present |-> !per_wr && !per_rd); // R10

  AST_FWD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    per_present && io_wr |-> per_wr); // R10
endmodule

bind guarded_mem_bridge pb_checker #(.WIDE_W(WIDE_W)) u_chk (.*);

// File: tb/tb_guarded_mem_bridge.sv
`timescale 1ns/100ps
module tb_guarded_mem_bridge;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic cfg_we, cfg_valid;
  logic [1:0] cfg_slot;
  logic [15:0] cfg_lo, cfg_hi;
  logic cpu_rd, cpu_wr;
  logic [15:0] cpu_addr, cpu_wdata;
  logic [7:0] cpu_rdata;
  logic dbg_load, dbg_wr;
  logic [15:0] dbg_addr, dbg_wdata;
  logic io_rd, io_wr;
  logic [15:0] io_port, io_wdata;
  logic [7:0] io_rdata;
  logic per_present;
  logic [7:0] per_rdata;
  logic per_rd, per_wr;
  logic [15:0] per_port;
  logic [7:0] per_wdata;

  guarded_mem_bridge dut (.*);

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference model state
  int          m_mem [int];
  bit          m_v [4];
  int          m_lo [4];
  int          m_hi [4];
  int          m_ptr;
  int          exp_rd;
  bit          exp_rd_known;

  function automatic bit m_guard(int a);
    for (int s = 0; s < 4; s++)
      if (m_v[s] && a >= m_lo[s] && a <= m_hi[s]) return 1;
    return 0;
  endfunction

  function automatic int m_idx(int a);
    return a % 1024;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Model update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) m_v[s] = 0;
      m_ptr = 0;
      exp_rd = 0;
      exp_rd_known = 1;
    end else begin
      if (cpu_rd) begin
        if (m_mem.exists(m_idx(cpu_addr))) begin
          exp_rd = m_mem[m_idx(cpu_addr)];
          exp_rd_known = 1;
        end else exp_rd_known = 0;
      end
      if (cpu_wr && !m_guard(cpu_addr)) m_mem[m_idx(cpu_addr)] = cpu_wdata % 256;
      if (dbg_load) m_ptr = dbg_addr;
      else if (dbg_wr && !cpu_wr) begin
        if (!m_guard(m_ptr)) m_mem[m_idx(m_ptr)] = dbg_wdata % 256;
        m_ptr = (m_ptr + 1) % 65536;
      end
      if (cfg_we) begin
        m_v[cfg_slot] = cfg_valid;
        m_lo[cfg_slot] = cfg_lo;
        m_hi[cfg_slot] = cfg_hi;
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_rd_known) check({cur_req, " cpu_rdata"}, cpu_rdata, exp_rd);
      check({cur_req, " io_rdata R9"}, io_rdata, per_present ? per_rdata : 8'hFF);
      check({cur_req, " per_wr R10"}, per_wr, io_wr && per_present);
      check({cur_req, " per_rd R10"}, per_rd, io_rd && per_present);
      check({cur_req, " per_port R10"}, per_port, io_port);
      check({cur_req, " per_wdata R10"}, per_wdata, io_wdata % 256);
    end
  end

  task automatic idle();
    cfg_we = 0; cpu_rd = 0; cpu_wr = 0; dbg_load = 0; dbg_wr = 0;
    io_rd = 0; io_wr = 0;
  endtask

  task automatic cyc_end();
    @(posedge clk); #1; idle();
  endtask

  task automatic cfg(int slot, bit v, int lo, int hi);
    @(posedge clk); #1;
    cfg_we = 1; cfg_slot = 2'(slot); cfg_valid = v; cfg_lo = 16'(lo); cfg_hi = 16'(hi);
    cyc_end();
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    cpu_wr = 1; cpu_addr = 16'(a); cpu_wdata = 16'(d);
    cyc_end();
  endtask

  task automatic rd(string req, int a, int exp);
    @(posedge clk); #1;
    cpu_rd = 1; cpu_addr = 16'(a);
    cyc_end();
    @(negedge clk);
    check(req, cpu_rdata, exp);
  endtask

  task automatic dload(int a);
    @(posedge clk); #1;
    dbg_load = 1; dbg_addr = 16'(a);
    cyc_end();
  endtask

  task automatic dwr(int d);
    @(posedge clk); #1;
    dbg_wr = 1; dbg_wdata = 16'(d);
    cyc_end();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0; cfg_slot = 0; cfg_valid = 0; cfg_lo = 0; cfg_hi = 0;
    cpu_addr = 0; cpu_wdata = 0; dbg_addr = 0; dbg_wdata = 0;
    io_port = 0; io_wdata = 0; per_present = 0; per_rdata = 8'h3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1 reset rdata", cpu_rdata, 0);
    wr(16'h0000, 8'h11); rd("R1 no window active", 16'h0000, 8'h11);
    wr(16'hFFF0, 8'h22); rd("R1 high address lands", 16'hFFF0, 8'h22);

    cur_req = "R3";
    wr(16'h0010, 16'hAB5A); rd("R3 low byte kept", 16'h0010, 8'h5A);
    wr(16'h0100, 8'hA0); wr(16'h0150, 8'hA5); wr(16'h01FF, 8'hAF);
    wr(16'h00FF, 8'h0F); wr(16'h0200, 8'h20);
    // write then read in the very next cycle
    @(posedge clk); #1 cpu_wr = 1; cpu_addr = 16'h0020; cpu_wdata = 16'h0077;
    @(posedge clk); #1 cpu_wr = 0; cpu_rd = 1;
    cyc_end(); @(negedge clk); check("R3 next-cycle read", cpu_rdata, 8'h77);

    cur_req = "R2";
    rd("R2 read latency", 16'h0150, 8'hA5);
    repeat (3) @(posedge clk);
    @(negedge clk); check("R2 rdata held", cpu_rdata, 8'hA5);
    // same-cycle read and write returns old contents
    @(posedge clk); #1 cpu_rd = 1; cpu_wr = 1; cpu_addr = 16'h0010; cpu_wdata = 16'h0099;
    cyc_end(); @(negedge clk); check("R2 read before write", cpu_rdata, 8'h5A);

    cur_req = "R4";
    cfg(1, 1, 16'h0100, 16'h01FF);
    wr(16'h0100, 8'hEE); wr(16'h01FF, 8'hEE); wr(16'h0150, 8'hEE);
    wr(16'h00FF, 8'hF1); wr(16'h0200, 8'hF2);
    rd("R4 lo bound guarded", 16'h0100, 8'hA0);
    rd("R4 hi bound guarded", 16'h01FF, 8'hAF);
    rd("R4 inside guarded", 16'h0150, 8'hA5);
    rd("R4 lo-1 lands", 16'h00FF, 8'hF1);
    rd("R4 hi+1 lands", 16'h0200, 8'hF2);

    cur_req = "R5";
    cfg(2, 0, 16'h0300, 16'h03FF);
    wr(16'h0340, 8'h34); rd("R5 invalid slot ignored", 16'h0340, 8'h34);
    cfg(3, 1, 16'h0380, 16'h0370);
    wr(16'h0375, 8'h75); rd("R5 inverted bounds no match", 16'h0375, 8'h75);
    wr(16'h0380, 8'h80); rd("R5 inverted bounds lo", 16'h0380, 8'h80);

    cur_req = "R6";
    dload(16'h0150); dwr(8'h66);
    rd("R6 debug write guarded", 16'h0150, 8'hA5);
    dload(16'h0050); dwr(8'h50); dwr(8'h51); dwr(16'hC352);
    rd("R6 debug lands 0x50", 16'h0050, 8'h50);
    rd("R6 debug lands 0x51", 16'h0051, 8'h51);
    rd("R6 debug low byte", 16'h0052, 8'h52);

    cur_req = "R7";
    dload(16'hFFFE); dwr(8'hE1); dwr(8'hE2); dwr(8'hE3);
    rd("R7 at 0xFFFE", 16'hFFFE, 8'hE1);
    rd("R7 at 0xFFFF", 16'hFFFF, 8'hE2);
    rd("R7 wrap to 0x0000", 16'h0000, 8'hE3);
    // load with write in the same cycle: write ignored
    wr(16'h0090, 8'h90);
    @(posedge clk); #1 dbg_load = 1; dbg_addr = 16'h0090; dbg_wr = 1; dbg_wdata = 16'h00DD;
    cyc_end();
    rd("R7 load cycle ignores write", 16'h0090, 8'h90);
    dwr(8'h91); rd("R7 write after load", 16'h0090, 8'h91);

    cur_req = "R8";
    wr(16'h0060, 8'h60);
    dload(16'h0060);
    @(posedge clk); #1 cpu_wr = 1; cpu_addr = 16'h0070; cpu_wdata = 16'h0070;
    dbg_wr = 1; dbg_wdata = 16'h00BB;
    cyc_end();
    rd("R8 cpu write wins", 16'h0070, 8'h70);
    rd("R8 debug write lost", 16'h0060, 8'h60);
    dwr(8'hCC);
    rd("R8 pointer held", 16'h0060, 8'hCC);
    rd("R8 next untouched", 16'h0061, 8'h00 + 8'h00 + (m_mem.exists(16'h61) ? 8'(m_mem[16'h61]) : 8'h00));

    cur_req = "R9";
    per_present = 0;
    @(posedge clk); #1 io_rd = 1; io_port = 16'h1234;
    @(negedge clk); check("R9 floating bus", io_rdata, 8'hFF);
    cyc_end();
    per_present = 1; per_rdata = 8'h5E;
    @(posedge clk); #1 io_rd = 1; io_port = 16'hAB02;
    @(negedge clk); check("R9 peripheral data", io_rdata, 8'h5E);
    check("R10 full port", per_port, 16'hAB02);
    cyc_end();

    cur_req = "R10";
    per_present = 0;
    @(posedge clk); #1 io_wr = 1; io_port = 16'h0080; io_wdata = 16'h1F2E;
    @(negedge clk); check("R10 discarded write", per_wr, 0);
    cyc_end();
    per_present = 1;
    @(posedge clk); #1 io_wr = 1; io_port = 16'hFF80; io_wdata = 16'h1F2E;
    @(negedge clk); check("R10 forwarded write", per_wr, 1);
    check("R10 low data byte", per_wdata, 8'h2E);
    cyc_end();
    repeat (2) @(posedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule